// File: doc/BRIEF.md
# Configuration Sequencer Controller

This controller takes a programmable device from power-up to a running user design in three fixed steps. First it clears configuration memory. Second it writes a stream of configuration words into that memory. Third it runs a short startup that hands control to the user logic. A power-on reset starts the sequence, and so does an active-low program request.

Two shared lines are open-drain, and each is modelled as a pull-low enable plus a sampled input. The init line stays low for the whole clear. After the clear, any outside agent may keep holding the line low, and loading waits until the line reads high. The done line is released only at the end. Global set/reset keeps every user flip-flop in reset until all the expected words have been written. A program request aborts any step, and releasing it starts the sequence again from the clear.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After rst_ni is released the block is in the clear step: clr_req_o=1, init_pull_o=1, gsr_o=1, done_pull_o=1, user_en_o=0, mem_we_o=0.
- R2: clr_req_o and init_pull_o stay 1 until clr_done_i is seen high at a clock edge. From the next cycle both are 0.
- R3: After the clear, no word is written while the sampled init line (init_i, passed through a two-flop synchronizer) reads 0. Loading begins only after it reads 1.
- R4: In the load step, each cycle with cfg_valid_i=1 writes one word. mem_wdata_o equals cfg_data_i, and mem_addr_o counts 0,1,2,... from the start of each sequence.
- R5: Exactly cfg_len_i words are written, and no more are accepted afterwards. done_pull_o stays 1 until they have all been written.
- R6: gsr_o is 1 throughout the clear and load steps. It goes to 0 one cycle before done_pull_o goes to 0. When the last word is accepted at edge k, gsr_o falls at edge k+1 and done_pull_o falls at edge k+2.
- R7: Within three clock edges of prog_ni going low, from any step, the block holds init_pull_o=1, done_pull_o=1, gsr_o=1, user_en_o=0, clr_req_o=0 and mem_we_o=0 for as long as prog_ni stays low. After prog_ni is released, the sequence restarts at the clear step.
- R8: When cfg_len_i is 0, the block goes from the load step straight to startup without writing any word.
- R9: Once the done step is reached, user_en_o=1 and done_pull_o=0 hold, and further cfg_valid_i pulses write nothing, until the next program request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| prog_ni | input | 1 | Active-low program request (asynchronous) |
| init_i | input | 1 | Sampled level of the open-drain init line |
| init_pull_o | output | 1 | Pull the init line low |
| clr_req_o | output | 1 | Request to the memory-clear engine |
| clr_done_i | input | 1 | Clear engine finished (synchronous) |
| cfg_data_i | input | DATA_W | Configuration word |
| cfg_valid_i | input | 1 | Configuration word valid strobe |
| cfg_len_i | input | CNT_W | Expected number of words |
| mem_we_o | output | 1 | Configuration memory write enable |
| mem_addr_o | output | CNT_W | Configuration memory write index |
| mem_wdata_o | output | DATA_W | Configuration memory write data |
| gsr_o | output | 1 | Global set/reset to user flip-flops |
| done_pull_o | output | 1 | Pull the done line low |
| user_en_o | output | 1 | User design enable |

## Verification
The assertions assume that cfg_len_i stays constant from the clear step until the next program request, and that clr_done_i pulses only while a clear is being requested. The bench sets the length before each sequence starts and only pulses the clear-done input after it has seen clr_req_o. It models both open-drain lines as a wired-AND of the controller's pull and a bench-side hold. The program request is driven asynchronously, and every check allows for the synchronizer delay.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_RESET,
    ST_CLEAR,
    ST_WAIT_INIT,
    ST_LOAD,
    ST_STARTUP,
    ST_DONE
  } cfg_state_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_len_cnt.sv
module cfg_len_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == len_i);

  // R5: the sequencer never pushes past the programmed length
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !full_o);
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_ni,
  input  logic              init_i,
  output logic              init_pull_o,
  output logic              clr_req_o,
  input  logic              clr_done_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  input  logic              cfg_valid_i,
  input  logic [CNT_W-1:0]  cfg_len_i,
  output logic              mem_we_o,
  output logic [CNT_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              gsr_o,
  output logic              done_pull_o,
  output logic              user_en_o
);
  localparam int unsigned NSYNC = 2;

  cfg_state_e       state_q, state_d;
  logic [NSYNC-1:0] raw_in, sync_out;
  logic             prog_s, init_s;
  logic             cnt_full;
  logic [CNT_W-1:0] cnt;

  assign raw_in = {prog_ni, init_i};

  cfg_sync #(.W(NSYNC), .STAGES(SYNC_N), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_out)
  );

  assign prog_s = sync_out[1];
  assign init_s = sync_out[0];

  always_comb begin
    state_d = state_q;
    if (!prog_s) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET:     state_d = ST_CLEAR;
        ST_CLEAR:     if (clr_done_i) state_d = ST_WAIT_INIT;
        ST_WAIT_INIT: if (init_s)     state_d = ST_LOAD;
        ST_LOAD:      if (cnt_full)   state_d = ST_STARTUP;
        ST_STARTUP:   state_d = ST_DONE;
        ST_DONE:      state_d = ST_DONE;
        default:      state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_CLEAR;
    else         state_q <= state_d;
  end

  assign mem_we_o = (state_q == ST_LOAD) && cfg_valid_i && !cnt_full && prog_s;

  cfg_len_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_CLEAR),
    .inc_i  (mem_we_o),
    .len_i  (cfg_len_i),
    .cnt_o  (cnt),
    .full_o (cnt_full)
  );

  assign mem_addr_o  = cnt;
  assign mem_wdata_o = cfg_data_i;
  assign clr_req_o   = (state_q == ST_CLEAR);
  assign init_pull_o = (state_q == ST_RESET) || (state_q == ST_CLEAR);
  assign gsr_o       = !((state_q == ST_STARTUP) || (state_q == ST_DONE));
  assign done_pull_o = (state_q != ST_DONE);
  assign user_en_o   = (state_q == ST_DONE);

  // R7: a synchronized program request always lands in reset
  a_r7_prog_forces_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_s |=> (state_q == ST_RESET));

  // R3: no load while the init line reads low
  a_r3_hold_while_init_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_INIT && !init_s) |=> (state_q != ST_LOAD));

  // R6: global reset released one cycle before done and user enable
  a_r6_gsr_drops_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(user_en_o) |-> $past(!gsr_o && done_pull_o));

  // R5: done only with the full length written
  a_r5_done_after_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_pull_o |-> (cnt == cfg_len_i));

  // R4: each write advances the address by one
  a_r4_addr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (mem_addr_o == CNT_W'($past(mem_addr_o) + 1'b1)));
endmodule

// File: tb/cfg_seq_ctrl_test.sv
`timescale 1ns/1ps
module cfg_seq_ctrl_test;
  localparam int DW = 8;
  localparam int CW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_n = 1'b1;
  logic ext_hold = 1'b0;
  logic clr_done = 1'b0;
  logic [DW-1:0] data = '0;
  logic valid = 1'b0;
  logic [CW-1:0] len = '0;
  logic init_line;
  logic init_pull, clr_req, mem_we, gsr, done_pull, user_en;
  logic [CW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  assign init_line = !(init_pull | ext_hold);

  cfg_seq_ctrl #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .prog_ni(prog_n), .init_i(init_line),
    .init_pull_o(init_pull), .clr_req_o(clr_req), .clr_done_i(clr_done),
    .cfg_data_i(data), .cfg_valid_i(valid), .cfg_len_i(len),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .gsr_o(gsr), .done_pull_o(done_pull), .user_en_o(user_en)
  );

  function automatic logic [DW-1:0] pat(int i);
    logic [DW-1:0] v = i[DW-1:0];
    return (v * 8'h3B) ^ 8'hA5;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(gsr == 1 && done_pull == 1 && user_en == 0, "R1", "outputs in reset", {gsr, done_pull, user_en}, 3'b110);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(clr_req == 1, "R1", "clr_req after reset", clr_req, 1);
    chk(init_pull == 1, "R1", "init pull after reset", init_pull, 1);
    chk({gsr, done_pull, user_en, mem_we} == 4'b1100, "R1", "gsr/done/user/we", {gsr, done_pull, user_en, mem_we}, 4'b1100);
  endtask

  task automatic prog_abort(int hold);
    @(posedge clk); #1 prog_n = 1'b0; valid = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < hold; c++) begin
      chk({init_pull, done_pull, gsr, user_en, clr_req, mem_we} == 6'b111000, "R7",
          "outputs while program held", {init_pull, done_pull, gsr, user_en, clr_req, mem_we}, 6'b111000);
      @(negedge clk);
    end
    @(posedge clk); #1 prog_n = 1'b1; valid = 1'b0;
  endtask

  // abort_at >= 0: issue a program request right after word abort_at is written
  task automatic cfg_run(int n, int stall, int abort_at);
    int i;
    int cyc;
    logic prev_gsr, first_gsr;
    len = CW'(n); valid = 1'b0;
    @(negedge clk);
    while (!clr_req) @(negedge clk);
    chk(init_pull == 1, "R2", "init pulled during clear", init_pull, 1);
    chk(gsr == 1, "R6", "gsr during clear", gsr, 1);
    repeat (3) @(posedge clk);
    #1 ext_hold = (stall > 0); clr_done = 1'b1;
    @(posedge clk); #1 clr_done = 1'b0;
    data = pat(0); valid = 1'b1;
    @(negedge clk);
    chk(clr_req == 0 && init_pull == 0, "R2", "released after clear", {clr_req, init_pull}, 0);
    for (int s = 0; s < stall; s++) begin
      chk(mem_we == 0, "R3", "no write while init held low", mem_we, 0);
      @(negedge clk);
    end
    if (stall > 0) begin
      @(posedge clk); #1 ext_hold = 1'b0;
    end
    i = 0;
    while (i < n) begin
      @(negedge clk);
      chk(done_pull == 1, "R5", "done before all words", done_pull, 1);
      if (mem_we) begin
        chk(mem_addr == CW'(i), "R4", "write address", mem_addr, i);
        chk(mem_wdata == pat(i), "R4", "write data", mem_wdata, pat(i));
        chk(gsr == 1, "R6", "gsr during load", gsr, 1);
        if (i == abort_at) begin
          prog_abort(3);
          return;
        end
        @(posedge clk); #1;
        i++;
        data = pat(i);
      end
    end
    cyc = 0; prev_gsr = 1'b1; first_gsr = 1'b0;
    @(negedge clk);
    first_gsr = gsr;
    while (done_pull) begin
      chk(mem_we == 0, "R5", "no write past length", mem_we, 0);
      prev_gsr = gsr;
      cyc++;
      @(negedge clk);
    end
    chk(user_en == 1, "R9", "user enable at done", user_en, 1);
    chk(prev_gsr == 0, "R6", "gsr low the cycle before done", prev_gsr, 0);
    if (n > 0) begin
      chk(first_gsr == 1, "R6", "gsr still high after last word", first_gsr, 1);
      chk(cyc == 2, "R6", "cycles from last word to done", cyc, 2);
    end else begin
      chk(1'b1, "R8", "zero length reached done", 1, 1);
    end
    valid = 1'b0;
  endtask

  task automatic t_hold_done();
    @(posedge clk); #1 valid = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk({user_en, done_pull, mem_we} == 3'b100, "R9", "done state holds", {user_en, done_pull, mem_we}, 3'b100);
    end
    valid = 1'b0;
  endtask

  task automatic t_zero_len();
    prog_abort(2);
    len = '0;
    cfg_run(0, 0, -1);
    chk(mem_addr == 0, "R8", "no word written for zero length", mem_addr, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    cfg_run(6, 0, -1);
    t_hold_done();
    prog_abort(4);
    cfg_run(8, 5, 3);
    cfg_run(8, 4, -1);
    t_zero_len();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule